// File: doc/BRIEF.md
# Master-Clocked Half-Duplex Frame Slave

This block is the slave end of a two-wire serial link. The master owns the link clock, and one data line carries traffic in both directions. Every transfer is a fixed twelve-bit packet. The start bit is low and the end bit is high. A two-bit control field follows the start bit and decides who drives the eight-bit data field after it. On a master write the slave collects the byte and hands it to the user side. On a master read the slave turns the shared line around, drives a byte that it took from the user side, and releases the line before the end bit. The pad is split into an input, an output value and an output enable.

The link clock and link data are synchronised into the system clock domain and oversampled. Rising link edges sample the line. Falling link edges move the slave's driven bit. The received-byte interface carries a valid strobe only. The master's clock cannot be paused, so there is no back-pressure: the user side must accept `rx_data` in the cycle `rx_valid` is high. The transmit byte is a plain register input that the slave captures once per read packet. A small decoder publishes the selected storage-address width. In extended mixed operation it also flags whether an address falls in the peripheral half.

Top module: `frame_slave`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `link_oe`, `rx_valid`, `framing_error` and `rd_active` are 0, and the slave is waiting for a start bit.
- R2: While waiting for a start bit, a rising link edge with the data line high has no effect. A rising edge with the line low is taken as bit 0, and the next eleven rising edges are bits 1 to 11. After bit 11 the slave waits for a start bit again.
- R3: Control code {bit1, bit2} = 2'b10 is a master write, and 2'b11 is a slave read. Codes 2'b00 and 2'b01 are idle: `link_oe` stays 0 for the whole packet and `rx_valid` does not pulse.
- R4: In a write packet, bits 3 to 10 are the data byte, least significant bit first. `rx_valid` is high for exactly one cycle after the rise of bit 10, with the whole byte on `rx_data`. There is no ready signal.
- R5: In a read packet, `link_oe` rises after the falling edge that begins bit 3 and falls after the falling edge that begins bit 11. Between these, `link_dout` carries the transmit byte least significant bit first. `link_dout` and `link_oe` change only after a falling link edge.
- R6: The transmit byte is captured at the end of bit 2, that is, at the falling edge that begins bit 3. A change to `tx_byte` before that edge is sent. A change after it does not affect the current packet.
- R7: If bit 11 is sampled low, `framing_error` is high for one cycle after that rise, and the slave waits for a start bit again. A write packet still delivers its `rx_valid` pulse after bit 10.
- R8: `rd_active` rises after the rise of bit 2 in a read packet and falls after the rise of bit 11.
- R9: Each output reacts at system clock edge SYNC_STAGES+1, counting as edge 1 the first edge that samples a new link level. The link clock must stay high and low for at least SYNC_STAGES+2 system clocks each.
- R10: `addr_width` is 21 when `ext_mode` is 0 and 28 when it is 1. `is_peripheral` is 1 only when `ext_mode` and `mixed_mode` are both 1 and bit 27 of `user_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_clk | input | 1 | Link clock from the master, asynchronous |
| link_din | input | 1 | Data line as seen at the pad |
| link_dout | output | 1 | Value the slave drives onto the data line |
| link_oe | output | 1 | Output enable for the data line |
| tx_byte | input | DATA_BITS | Byte to send on a read packet |
| rx_valid | output | 1 | One-cycle strobe, received byte present |
| rx_data | output | DATA_BITS | Received byte |
| rd_active | output | 1 | Current packet is a slave read |
| framing_error | output | 1 | One-cycle strobe, end bit was low |
| ext_mode | input | 1 | Select extended address range |
| mixed_mode | input | 1 | Split the extended range into peripheral and storage halves |
| user_addr | input | ADDR_EXT | Address to classify |
| addr_width | output | $clog2(ADDR_EXT+1) | Active storage-address width |
| is_peripheral | output | 1 | Address lies in the peripheral half |

## Verification
The bench builds the block with its defaults: two synchroniser stages, eight data bits in a twelve-bit frame, and address widths of 21 and 28. With two stages the link clock can run at a half-period of four system clocks. The bench drives that tightest legal rate and also a slower half-period of seven, so the turnaround margin at bit 3 and the release before bit 11 are exercised at the limit of R9. All four mode-input combinations and both values of the top address bit can be reached.

// File: rtl/frame_slave_pkg.sv
package frame_slave_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WR   = 2'd1,
    MODE_RD   = 2'd2
  } pkt_mode_e;

  localparam logic [1:0] CTL_WRITE = 2'b10;
  localparam logic [1:0] CTL_READ  = 2'b11;

  function automatic pkt_mode_e ctl_decode(input logic [1:0] code);
    case (code)
      CTL_WRITE: ctl_decode = MODE_WR;
      CTL_READ:  ctl_decode = MODE_RD;
      default:   ctl_decode = MODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/fs_edge_sync.sv
module fs_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_clk,
  input  logic link_din,
  output logic clk_rise,
  output logic clk_fall,
  output logic din_s
);
  logic [SYNC_STAGES-1:0] clk_chain;
  logic [SYNC_STAGES-1:0] din_chain;
  logic                   clk_prev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          clk_chain[g] <= 1'b1;
          din_chain[g] <= 1'b1;
        end else if (g == 0) begin
          clk_chain[g] <= link_clk;
          din_chain[g] <= link_din;
        end else begin
          clk_chain[g] <= clk_chain[(g == 0) ? 0 : g-1];
          din_chain[g] <= din_chain[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= clk_chain[SYNC_STAGES-1];
  end

  assign clk_rise = clk_chain[SYNC_STAGES-1] & ~clk_prev;
  assign clk_fall = ~clk_chain[SYNC_STAGES-1] & clk_prev;
  assign din_s    = din_chain[SYNC_STAGES-1];

endmodule

// File: rtl/fs_frame_engine.sv
module fs_frame_engine
  import frame_slave_pkg::*;
#(
  parameter int FRAME_BITS = 12,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_rise,
  input  logic                 clk_fall,
  input  logic                 din_s,
  input  logic [DATA_BITS-1:0] tx_byte,
  output logic                 link_oe,
  output logic                 link_dout,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rd_active,
  output logic                 framing_error
);
  localparam int CW         = $clog2(FRAME_BITS + 1);
  localparam int DIW        = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int DATA_FIRST = 3;
  localparam int DATA_LAST  = DATA_FIRST + DATA_BITS - 1;
  localparam int END_BIT    = FRAME_BITS - 1;

  logic                 hunting;
  logic [CW-1:0]        bit_idx;
  pkt_mode_e            mode;
  logic                 ctl_hi;
  logic [DATA_BITS-1:0] rx_shift;
  logic [DATA_BITS-1:0] tx_shift;
  logic [DATA_BITS-1:0] rx_next;
  logic [DIW-1:0]       data_pos;
  logic                 in_data;

  always_comb begin
    data_pos = DIW'(bit_idx - CW'(DATA_FIRST));
    in_data  = (bit_idx >= CW'(DATA_FIRST)) && (bit_idx <= CW'(DATA_LAST));
    rx_next  = rx_shift;
    if (in_data) rx_next[data_pos] = din_s;
  end

  // sampling side: rising link edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hunting       <= 1'b1;
      bit_idx       <= '0;
      mode          <= MODE_IDLE;
      ctl_hi        <= 1'b0;
      rx_shift      <= '0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      rd_active     <= 1'b0;
      framing_error <= 1'b0;
    end else begin
      rx_valid      <= 1'b0;
      framing_error <= 1'b0;
      if (clk_rise) begin
        if (hunting) begin
          if (!din_s) begin
            hunting <= 1'b0;
            bit_idx <= CW'(1);
            mode    <= MODE_IDLE;
          end
        end else begin
          bit_idx <= bit_idx + CW'(1);
          if (bit_idx == CW'(1)) begin
            ctl_hi <= din_s;
          end else if (bit_idx == CW'(2)) begin
            mode      <= ctl_decode({ctl_hi, din_s});
            rd_active <= (ctl_decode({ctl_hi, din_s}) == MODE_RD);
          end else if (in_data) begin
            if (mode == MODE_WR) begin
              rx_shift <= rx_next;
              if (bit_idx == CW'(DATA_LAST)) begin
                rx_data  <= rx_next;
                rx_valid <= 1'b1;
              end
            end
          end else if (bit_idx == CW'(END_BIT)) begin
            framing_error <= ~din_s;
            hunting       <= 1'b1;
            rd_active     <= 1'b0;
            mode          <= MODE_IDLE;
          end
        end
      end
    end
  end

  // driving side: falling link edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_oe   <= 1'b0;
      link_dout <= 1'b0;
      tx_shift  <= '0;
    end else if (clk_fall && !hunting && (mode == MODE_RD)) begin
      if (bit_idx == CW'(DATA_FIRST)) begin
        tx_shift  <= tx_byte;
        link_dout <= tx_byte[0];
        link_oe   <= 1'b1;
      end else if (in_data) begin
        link_dout <= tx_shift[data_pos];
      end else if (bit_idx == CW'(END_BIT)) begin
        link_oe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fs_addr_decode.sv
module fs_addr_decode #(
  parameter int ADDR_STD = 21,
  parameter int ADDR_EXT = 28
) (
  input  logic                          ext_mode,
  input  logic                          mixed_mode,
  input  logic [ADDR_EXT-1:0]           user_addr,
  output logic [$clog2(ADDR_EXT+1)-1:0] addr_width,
  output logic                          is_peripheral
);
  localparam int WW = $clog2(ADDR_EXT + 1);

  always_comb begin
    addr_width    = ext_mode ? WW'(ADDR_EXT) : WW'(ADDR_STD);
    is_peripheral = ext_mode & mixed_mode & ~user_addr[ADDR_EXT-1];
  end

endmodule

// File: rtl/frame_slave.sv
module frame_slave #(
  parameter int FRAME_BITS  = 12,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_STD    = 21,
  parameter int ADDR_EXT    = 28
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          link_clk,
  input  logic                          link_din,
  output logic                          link_dout,
  output logic                          link_oe,
  input  logic [DATA_BITS-1:0]          tx_byte,
  output logic                          rx_valid,
  output logic [DATA_BITS-1:0]          rx_data,
  output logic                          rd_active,
  output logic                          framing_error,
  input  logic                          ext_mode,
  input  logic                          mixed_mode,
  input  logic [ADDR_EXT-1:0]           user_addr,
  output logic [$clog2(ADDR_EXT+1)-1:0] addr_width,
  output logic                          is_peripheral
);
  logic link_rise;
  logic link_fall;
  logic link_din_s;

  fs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_clk (link_clk),
    .link_din (link_din),
    .clk_rise (link_rise),
    .clk_fall (link_fall),
    .din_s    (link_din_s)
  );

  fs_frame_engine #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .clk_rise      (link_rise),
    .clk_fall      (link_fall),
    .din_s         (link_din_s),
    .tx_byte       (tx_byte),
    .link_oe       (link_oe),
    .link_dout     (link_dout),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rd_active     (rd_active),
    .framing_error (framing_error)
  );

  fs_addr_decode #(.ADDR_STD(ADDR_STD), .ADDR_EXT(ADDR_EXT)) u_addr (
    .ext_mode      (ext_mode),
    .mixed_mode    (mixed_mode),
    .user_addr     (user_addr),
    .addr_width    (addr_width),
    .is_peripheral (is_peripheral)
  );

endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int ADDR_EXT = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                link_rise,
  input logic                link_fall,
  input logic                link_oe,
  input logic                link_dout,
  input logic                rx_valid,
  input logic                rd_active,
  input logic                framing_error,
  input logic                ext_mode,
  input logic [ADDR_EXT-1:0] user_addr,
  input logic                is_peripheral
);
  p_oe_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_oe |-> rd_active);

  p_oe_rise_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_oe) |-> $past(link_fall));

  p_pad_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !link_fall |=> ($stable(link_dout) && $stable(link_oe)));

  p_rx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_rx_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(link_rise));

  p_rx_not_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rd_active);

  p_ferr_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    framing_error |-> $past(link_rise));

  p_ferr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    framing_error |=> !framing_error);

  p_periph_std_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !is_peripheral);

  p_periph_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    user_addr[ADDR_EXT-1] |-> !is_peripheral);

endmodule

bind frame_slave fs_checker #(.ADDR_EXT(ADDR_EXT)) u_fs_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .link_rise     (link_rise),
  .link_fall     (link_fall),
  .link_oe       (link_oe),
  .link_dout     (link_dout),
  .rx_valid      (rx_valid),
  .rd_active     (rd_active),
  .framing_error (framing_error),
  .ext_mode      (ext_mode),
  .user_addr     (user_addr),
  .is_peripheral (is_peripheral)
);

// File: tb/test_frame_slave.sv
`timescale 1ns/1ps
module test_frame_slave;
  localparam int SYNC = 2;
  localparam int AE   = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_clk = 1'b1;
  logic m_drv = 1'b1;
  logic link_din;
  logic link_dout, link_oe;
  logic [7:0] tx_byte = 8'h00;
  logic rx_valid, rd_active, framing_error;
  logic [7:0] rx_data;
  logic ext_mode = 1'b0, mixed_mode = 1'b0;
  logic [AE-1:0] user_addr = '0;
  logic [4:0] addr_width;
  logic is_peripheral;

  int checks = 0;
  int failures = 0;
  int rx_cnt = 0, fe_cnt = 0, oe_cycles = 0, rda_cycles = 0;
  logic [7:0] last_rx = 8'h00;

  always #5 clk = ~clk;

  // shared data line: slave wins while enabled
  assign link_din = link_oe ? link_dout : m_drv;

  frame_slave i_frame_slave (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_din(link_din),
    .link_dout(link_dout), .link_oe(link_oe), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_data(rx_data), .rd_active(rd_active),
    .framing_error(framing_error), .ext_mode(ext_mode), .mixed_mode(mixed_mode),
    .user_addr(user_addr), .addr_width(addr_width), .is_peripheral(is_peripheral)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int qc[$];
  int qd[$];
  int m_hunt, m_idx, m_kind, m_c1;    // m_kind: 0 idle, 1 write, 2 read
  int m_rx_acc, m_tx_acc;
  int e_oe, e_dout, e_rxv, e_rxd, e_rda, e_fe;

  always @(posedge clk) begin
    if (!rst_n) begin
      qc.delete(); qd.delete();
      for (int i = 0; i < SYNC + 2; i++) begin qc.push_back(1); qd.push_back(1); end
      m_hunt = 1; m_idx = 0; m_kind = 0; m_c1 = 0; m_rx_acc = 0; m_tx_acc = 0;
      e_oe = 0; e_dout = 0; e_rxv = 0; e_rxd = 0; e_rda = 0; e_fe = 0;
    end else begin
      int c_now, c_old, d_now;
      qc.push_front(int'(link_clk)); qd.push_front(int'(link_din));
      void'(qc.pop_back()); void'(qd.pop_back());
      c_now = qc[SYNC]; c_old = qc[SYNC+1]; d_now = qd[SYNC];
      e_rxv = 0; e_fe = 0;
      if (c_now == 1 && c_old == 0) begin
        if (m_hunt == 1) begin
          if (d_now == 0) begin m_hunt = 0; m_idx = 1; m_kind = 0; m_rx_acc = 0; end
        end else begin
          if (m_idx == 1) m_c1 = d_now;
          else if (m_idx == 2) begin
            m_kind = (m_c1 == 1) ? ((d_now == 1) ? 2 : 1) : 0;
            e_rda = (m_kind == 2);
          end else if (m_idx <= 10) begin
            if (m_kind == 1) begin
              m_rx_acc = m_rx_acc | (d_now << (m_idx - 3));
              if (m_idx == 10) begin e_rxv = 1; e_rxd = m_rx_acc; end
            end
          end else begin
            e_fe = (d_now == 0); m_hunt = 1; e_rda = 0; m_kind = 0;
          end
          m_idx++;
        end
      end else if (c_now == 0 && c_old == 1 && m_hunt == 0 && m_kind == 2) begin
        if (m_idx == 3) begin m_tx_acc = int'(tx_byte); e_oe = 1; e_dout = m_tx_acc & 1; end
        else if (m_idx <= 10) e_dout = (m_tx_acc >> (m_idx - 3)) & 1;
        else if (m_idx == 11) e_oe = 0;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(link_oe === e_oe[0], "R5 R9 link_oe", link_oe, e_oe);
      if (e_oe == 1) chk(link_dout === e_dout[0], "R5 R9 link_dout", link_dout, e_dout);
      chk(rx_valid === e_rxv[0], "R4 R9 rx_valid", rx_valid, e_rxv);
      if (e_rxv == 1) chk(rx_data === e_rxd[7:0], "R4 rx_data", rx_data, e_rxd);
      chk(framing_error === e_fe[0], "R7 framing_error", framing_error, e_fe);
      chk(rd_active === e_rda[0], "R8 rd_active", rd_active, e_rda);
      chk(addr_width === (ext_mode ? 5'd28 : 5'd21), "R10 addr_width", addr_width,
          ext_mode ? 28 : 21);
      chk(is_peripheral === (ext_mode && mixed_mode && !user_addr[AE-1]),
          "R10 is_peripheral", is_peripheral, ext_mode && mixed_mode && !user_addr[AE-1]);
      if (rx_valid) begin rx_cnt++; last_rx = rx_data; end
      if (framing_error) fe_cnt++;
      if (link_oe) oe_cycles++;
      if (rd_active) rda_cycles++;
    end
  end

  // ---------------- master driver ----------------
  task automatic frame(input logic [1:0] ctl, input logic [7:0] data, input logic endb,
                       input int half, input int chg_bit, input logic [7:0] new_tx,
                       output logic [7:0] got);
    got = 8'h00;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      link_clk = 1'b0;
      if (k == 0) m_drv = 1'b0;
      else if (k == 1) m_drv = ctl[1];
      else if (k == 2) m_drv = ctl[0];
      else if (k <= 10) m_drv = (ctl == 2'b11) ? 1'b1 : data[k-3];
      else m_drv = endb;
      if (k == chg_bit) tx_byte = new_tx;
      repeat (half - 1) @(negedge clk);
      link_clk = 1'b1;
      if (k >= 3 && k <= 10) got[k-3] = link_din;
      repeat (half - 1) @(negedge clk);
    end
    @(negedge clk); m_drv = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int rx0, fe0, oe0, rda0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(link_oe === 1'b0 && rx_valid === 1'b0 && framing_error === 1'b0 && rd_active === 1'b0,
        "R1 outputs in reset", {link_oe, rx_valid, framing_error, rd_active}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_oe === 1'b0 && rx_valid === 1'b0 && rd_active === 1'b0,
        "R1 outputs after reset", {link_oe, rx_valid, rd_active}, 0);

    // R10 address decode combinations
    ext_mode = 0; mixed_mode = 1; user_addr = '0; @(negedge clk);
    chk(addr_width == 21 && !is_peripheral, "R10 standard", {addr_width, is_peripheral}, 21 << 1);
    ext_mode = 1; mixed_mode = 0; @(negedge clk);
    chk(addr_width == 28 && !is_peripheral, "R10 extended", {addr_width, is_peripheral}, 28 << 1);
    mixed_mode = 1; user_addr = 28'h0123456; @(negedge clk);
    chk(is_peripheral === 1'b1, "R10 mixed lower half", is_peripheral, 1);
    user_addr = 28'h8000001; @(negedge clk);
    chk(is_peripheral === 1'b0, "R10 mixed upper half", is_peripheral, 0);

    // R4 write at the tightest rate and a slower one (R9)
    rx0 = rx_cnt;
    frame(2'b10, 8'h5A, 1'b1, 4, -1, 8'h00, got);
    chk(rx_cnt == rx0 + 1 && last_rx == 8'h5A, "R4 write 0x5A half=4", last_rx, 8'h5A);
    frame(2'b10, 8'h81, 1'b1, 7, -1, 8'h00, got);
    chk(rx_cnt == rx0 + 2 && last_rx == 8'h81, "R4 R9 write 0x81 half=7", last_rx, 8'h81);

    // R5 R8 read
    tx_byte = 8'hA5; rda0 = rda_cycles;
    frame(2'b11, 8'h00, 1'b1, 4, -1, 8'h00, got);
    chk(got == 8'hA5, "R5 read byte half=4", got, 8'hA5);
    chk(rda_cycles > rda0 && rd_active === 1'b0, "R8 rd_active span", rda_cycles - rda0, 1);
    chk(link_oe === 1'b0, "R5 line released", link_oe, 0);
    frame(2'b11, 8'h00, 1'b1, 7, -1, 8'h00, got);
    chk(got == 8'hA5, "R5 R9 read byte half=7", got, 8'hA5);

    // R6 change after capture is not sent, change before capture is
    frame(2'b11, 8'h00, 1'b1, 4, 5, 8'h3C, got);
    chk(got == 8'hA5, "R6 late tx change ignored", got, 8'hA5);
    frame(2'b11, 8'h00, 1'b1, 4, -1, 8'h00, got);
    chk(got == 8'h3C, "R6 new byte next packet", got, 8'h3C);
    frame(2'b11, 8'h00, 1'b1, 5, 2, 8'hC3, got);
    chk(got == 8'hC3, "R6 change during bit 2 sent", got, 8'hC3);

    // R3 idle codes
    rx0 = rx_cnt; oe0 = oe_cycles;
    frame(2'b00, 8'hFF, 1'b1, 4, -1, 8'h00, got);
    frame(2'b01, 8'h0F, 1'b1, 4, -1, 8'h00, got);
    chk(rx_cnt == rx0, "R3 idle no rx", rx_cnt - rx0, 0);
    chk(oe_cycles == oe0, "R3 idle no drive", oe_cycles - oe0, 0);

    // R7 bad end bit, then recovery
    rx0 = rx_cnt; fe0 = fe_cnt;
    frame(2'b10, 8'h66, 1'b0, 4, -1, 8'h00, got);
    chk(fe_cnt == fe0 + 1, "R7 framing error flagged", fe_cnt - fe0, 1);
    chk(rx_cnt == rx0 + 1 && last_rx == 8'h66, "R7 rx still given", last_rx, 8'h66);
    frame(2'b10, 8'h99, 1'b1, 4, -1, 8'h00, got);
    chk(fe_cnt == fe0 + 1 && last_rx == 8'h99, "R7 recovers", last_rx, 8'h99);

    // R2 clock pulses with line high are ignored while hunting
    rx0 = rx_cnt; oe0 = oe_cycles;
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); link_clk = 1'b0; repeat (3) @(negedge clk);
      link_clk = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk(rx_cnt == rx0 && oe_cycles == oe0 && rd_active === 1'b0, "R2 high line ignored",
        rx_cnt - rx0, 0);
    frame(2'b10, 8'h24, 1'b1, 4, -1, 8'h00, got);
    chk(rx_cnt == rx0 + 1 && last_rx == 8'h24, "R2 start found after idle pulses", last_rx, 8'h24);

    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule